// File: doc/BRIEF.md
# Dual-Bank Context Switcher

This block is a context-switch coprocessor for an execution core. It holds two register banks. The core runs out of one of them, the active bank. The switcher works on the other one, the shadow bank. Each bank holds one context: a status word (word 0) followed by `NREG` general and stack-buffer registers (words 1..`NREG`). While the core runs, the switcher preloads the next runnable task into the shadow bank. A switch request can then be served by flipping the bank select at the next clock edge, with no stall.

After a flip, the switcher works in the background while the core keeps running. It writes the outgoing context to that task's control block in local memory. It then reads the link word of the new active task's block, follows that link, and loads the next task's context into the shadow bank. Once the shadow bank is ready, the switcher stops until the next switch. When a request arrives and the shadow bank is not ready, the core sees `ctxValid` low until the flip can take place. Trap and interrupt causes never flip the banks, because they are serviced in the running context.

Each control block occupies `NREG+2` consecutive words. The link to the next block (0 meaning none) comes first, then the status word, then the registers in index order. The scheduler that builds the list, and the core itself, lie outside this block.

Top module: `ctx_switch_engine`

## Requirements
- R1: The core reads `coreRdata` combinationally from the active bank at word `coreIdx`. A write (`coreWe`) takes effect only while `ctxValid` is high; a write attempted while it is low changes no bank.
- R2: A request with `swCause` 0 (terminate) or 1 (block) that arrives while the shadow bank is ready and `ctxValid` is high flips the banks at that clock edge. `ctxValid` stays high and the next read returns the new task's context.
- R3: A request with `swCause` 2 (trap) or 3 (interrupt) causes no flip, no memory traffic and no change of `ctxValid`.
- R4: A terminate or block request made while the shadow bank is not ready drops `ctxValid` at that edge. The request is held, and `ctxValid` rises one cycle after the shadow load completes, together with the flip. Further requests while `ctxValid` is low are ignored.
- R5: After a flip, the outgoing bank is written to words +1..+`NREG`+1 of the outgoing block, in word order. The save is skipped when the outgoing block address is 0.
- R6: After the save, the switcher reads word 0 of the new active task's block as the link. It then loads words +1..+`NREG`+1 of the linked block into the shadow bank, in word order.
- R7: A null link puts the switcher into an empty wait. Only a `resched` pulse ends that wait, and it then loads from `headPtr`; a `headPtr` of 0 keeps it waiting. `resched` has no effect in any other state.
- R8: `memReq` stays high with stable `memAddr`, `memWe` and `memWdata` until a cycle with `memGnt` high. Each such cycle moves one word, and reads take `memRdata` in that same cycle.
- R9: After reset, `ctxValid` is low, `memReq` is low and both banks are zero. The first task loaded after a `resched` becomes active automatically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swReq | input | 1 | Switch request pulse from the core |
| swCause | input | 2 | 0 terminate, 1 block, 2 trap, 3 interrupt |
| resched | input | 1 | Re-examine the list head while the list is empty |
| headPtr | input | ADDR_W | Address of the list head block |
| coreWe | input | 1 | Core write to the active bank |
| coreIdx | input | IDX_W | Context word index (0 = status word) |
| coreWdata | input | DATA_W | Core write data |
| coreRdata | output | DATA_W | Active bank word at coreIdx |
| ctxValid | output | 1 | Active context valid; low holds the core off |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | Transfer is a write |
| memAddr | output | ADDR_W | Word address |
| memWdata | output | DATA_W | Write data |
| memRdata | input | DATA_W | Read data, valid in the grant cycle |
| memGnt | input | 1 | Memory accepts the current transfer |

## Verification
The switch path is driven in four patterns. A request while the shadow bank is ready shows whether the flip costs no cycle. A request made right after a flip, while the save is still running, shows whether the request is held and whether the stall lasts exactly until the load completes. A trap request separates the causes that flip the banks from those that must not. Walking to the end of the list, then sending a reschedule with a zero head and then with a real head, tells the empty wait apart from a normal halt. A reschedule sent during a normal halt must change nothing. Grants are withheld on a pseudo-random pattern throughout, so that request hold and word ordering are checked under stalls.

// File: rtl/ctxsw_pkg.sv
package ctxsw_pkg;

  typedef enum logic [1:0] {
    CAUSE_TERM  = 2'd0,
    CAUSE_BLOCK = 2'd1,
    CAUSE_TRAP  = 2'd2,
    CAUSE_IRQ   = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    ADR_SAVE = 2'd0,
    ADR_LINK = 2'd1,
    ADR_LOAD = 2'd2
  } adrSel_e;

  // strobes from sequencer to datapath
  typedef struct packed {
    logic    swap;
    logic    loadWr;
    logic    candMem;
    logic    candHead;
    logic    commit;
    adrSel_e adrSel;
  } strobe_t;

endpackage

// File: rtl/ctxsw_ctl.sv
module ctxsw_ctl
  import ctxsw_pkg::*;
#(
  parameter int NW    = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swReq,
  input  logic [1:0]       swCause,
  input  logic             resched,
  input  logic             headNull,
  input  logic             activeNull,
  input  logic             linkNull,
  input  logic             memGnt,
  output strobe_t          stb,
  output logic [IDX_W-1:0] idx,
  output logic             memReq,
  output logic             memWe,
  output logic             ctxValid,
  output logic             nextRdy
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NW - 1);

  typedef enum logic [2:0] {ST_HALT, ST_SAVE, ST_LINK, ST_LOAD, ST_EMPTY} state_e;

  state_e state;
  logic   pend;
  logic   swTake;
  logic   doSwap;
  logic   isLast;

  assign swTake = swReq && !pend &&
                  ((swCause == CAUSE_TERM) || (swCause == CAUSE_BLOCK));
  assign doSwap = (state == ST_HALT) && (pend || swTake);
  assign isLast = (idx == LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_EMPTY;
      pend  <= 1'b1;
      idx   <= '0;
    end else begin
      if (swTake && state != ST_HALT) pend <= 1'b1;
      unique case (state)
        ST_HALT: begin
          if (doSwap) begin
            pend  <= 1'b0;
            idx   <= '0;
            state <= activeNull ? ST_LINK : ST_SAVE;
          end
        end
        ST_SAVE: begin
          if (memGnt) begin
            if (isLast) begin
              idx   <= '0;
              state <= ST_LINK;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_LINK: begin
          if (memGnt) begin
            idx   <= '0;
            state <= linkNull ? ST_EMPTY : ST_LOAD;
          end
        end
        ST_LOAD: begin
          if (memGnt) begin
            if (isLast) begin
              idx   <= '0;
              state <= ST_HALT;
            end else begin
              idx <= idx + 1'b1;
            end
          end
        end
        ST_EMPTY: begin
          if (resched && !headNull) begin
            idx   <= '0;
            state <= ST_LOAD;
          end
        end
        default: state <= ST_EMPTY;
      endcase
    end
  end

  always_comb begin
    stb          = '0;
    stb.swap     = doSwap;
    stb.loadWr   = (state == ST_LOAD) && memGnt;
    stb.commit   = (state == ST_LOAD) && memGnt && isLast;
    stb.candMem  = (state == ST_LINK) && memGnt;
    stb.candHead = (state == ST_EMPTY) && resched;
    case (state)
      ST_SAVE: stb.adrSel = ADR_SAVE;
      ST_LOAD: stb.adrSel = ADR_LOAD;
      default: stb.adrSel = ADR_LINK;
    endcase
  end

  assign memReq   = (state == ST_SAVE) || (state == ST_LINK) || (state == ST_LOAD);
  assign memWe    = (state == ST_SAVE);
  assign ctxValid = !pend;
  assign nextRdy  = (state == ST_HALT);

endmodule

// File: rtl/ctxsw_dp.sv
module ctxsw_dp
  import ctxsw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8,
  parameter int NW     = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [IDX_W-1:0]  idx,
  input  logic [ADDR_W-1:0] headPtr,
  input  logic              ctxValid,
  input  logic              coreWe,
  input  logic [IDX_W-1:0]  coreIdx,
  input  logic [DATA_W-1:0] coreWdata,
  output logic [DATA_W-1:0] coreRdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              headNull,
  output logic              activeNull,
  output logic              linkNull
);

  logic                   actSel;
  logic [ADDR_W-1:0]      activePcb, idlePcb, outPcb, candPcb;
  logic [1:0][DATA_W-1:0] rowRd;
  logic [1:0][DATA_W-1:0] rowSave;
  logic                   coreOk;
  logic                   coreWr;

  assign coreOk = (int'(coreIdx) < NW);
  assign coreWr = coreWe && ctxValid && coreOk;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] word [NW];
    logic              isAct;
    assign isAct = (actSel == 1'(b));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < NW; i++) word[i] <= '0;
      end else if (isAct && coreWr) begin
        word[coreIdx] <= coreWdata;
      end else if (!isAct && stb.loadWr) begin
        word[idx] <= memRdata;
      end
    end
    assign rowRd[b]   = coreOk ? word[coreIdx] : '0;
    assign rowSave[b] = word[idx];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actSel    <= 1'b0;
      activePcb <= '0;
      idlePcb   <= '0;
      outPcb    <= '0;
      candPcb   <= '0;
    end else begin
      if (stb.swap) begin
        actSel    <= ~actSel;
        outPcb    <= activePcb;
        activePcb <= idlePcb;
      end
      if (stb.candMem)  candPcb <= memRdata[ADDR_W-1:0];
      if (stb.candHead) candPcb <= headPtr;
      if (stb.commit)   idlePcb <= candPcb;
    end
  end

  always_comb begin
    case (stb.adrSel)
      ADR_SAVE: memAddr = outPcb + ADDR_W'(1) + ADDR_W'(idx);
      ADR_LOAD: memAddr = candPcb + ADDR_W'(1) + ADDR_W'(idx);
      default:  memAddr = activePcb;
    endcase
  end

  assign coreRdata  = rowRd[actSel];
  assign memWdata   = rowSave[~actSel];
  assign headNull   = (headPtr == '0);
  assign activeNull = (activePcb == '0);
  assign linkNull   = (memRdata[ADDR_W-1:0] == '0);

endmodule

// File: rtl/ctx_switch_engine.sv
module ctx_switch_engine
  import ctxsw_pkg::*;
#(
  parameter  int DATA_W = 16,
  parameter  int ADDR_W = 8,
  parameter  int NREG   = 3,
  localparam int NW     = NREG + 1,
  localparam int IDX_W  = $clog2(NW)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swReq,
  input  logic [1:0]        swCause,
  input  logic              resched,
  input  logic [ADDR_W-1:0] headPtr,
  input  logic              coreWe,
  input  logic [IDX_W-1:0]  coreIdx,
  input  logic [DATA_W-1:0] coreWdata,
  output logic [DATA_W-1:0] coreRdata,
  output logic              ctxValid,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memGnt
);

  strobe_t          stb;
  logic [IDX_W-1:0] idx;
  logic             headNull, activeNull, linkNull;
  logic             nextRdy;

  ctxsw_ctl #(.NW(NW), .IDX_W(IDX_W)) u_ctl (
    .clk(clk), .rstN(rstN), .swReq(swReq), .swCause(swCause),
    .resched(resched), .headNull(headNull), .activeNull(activeNull),
    .linkNull(linkNull), .memGnt(memGnt), .stb(stb), .idx(idx),
    .memReq(memReq), .memWe(memWe), .ctxValid(ctxValid), .nextRdy(nextRdy)
  );

  ctxsw_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NW(NW), .IDX_W(IDX_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .idx(idx), .headPtr(headPtr),
    .ctxValid(ctxValid), .coreWe(coreWe), .coreIdx(coreIdx),
    .coreWdata(coreWdata), .coreRdata(coreRdata), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata), .headNull(headNull),
    .activeNull(activeNull), .linkNull(linkNull)
  );

endmodule

// File: rtl/ctx_switch_engine_chk.sv
module ctx_switch_engine_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              swReq,
  input logic [1:0]        swCause,
  input logic              ctxValid,
  input logic              nextRdy,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memGnt
);

  // R8
  hold_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memGnt |=> memReq && $stable(memAddr) && $stable(memWe) && $stable(memWdata));

  // R2
  swap_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctxValid && nextRdy && swReq && (swCause < 2'd2) |=> ctxValid);

  // R3
  trap_no_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctxValid && swReq && (swCause >= 2'd2) |=> ctxValid);

  // R4
  stall_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctxValid && !nextRdy && swReq && (swCause < 2'd2) |=> !ctxValid);

  // R4
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctxValid) |-> $past(nextRdy));

  // R6
  quiet_when_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    nextRdy |-> !memReq);

endmodule

bind ctx_switch_engine ctx_switch_engine_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .swReq(swReq), .swCause(swCause), .ctxValid(ctxValid),
  .nextRdy(nextRdy), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
  .memWdata(memWdata), .memGnt(memGnt)
);

// File: tb/sim_ctx_switch_engine.sv
`timescale 1ns/1ps
module sim_ctx_switch_engine;

  localparam int DW = 16;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          swReq = 1'b0;
  logic [1:0]    swCause = 2'd0;
  logic          resched = 1'b0;
  logic [AW-1:0] headPtr = '0;
  logic          coreWe = 1'b0;
  logic [1:0]    coreIdx = '0;
  logic [DW-1:0] coreWdata = '0;
  logic [DW-1:0] coreRdata;
  logic          ctxValid, memReq, memWe, memGnt;
  logic [AW-1:0] memAddr;
  logic [DW-1:0] memWdata, memRdata;

  logic [DW-1:0] dutMem [256];
  logic [7:0]    lfsr = 8'hA5;

  int nChk = 0;
  int nBad = 0;
  int cyc  = 0;

  // behavioural reference state
  int refBank [2][4];
  int refMem  [256];
  int refAct, refPcbAct, refPcbIdle, refPcbOut, refCand, refMode, refCnt, refPend;

  always #5 clk = ~clk;

  ctx_switch_engine u0 (
    .clk(clk), .rstN(rstN), .swReq(swReq), .swCause(swCause), .resched(resched),
    .headPtr(headPtr), .coreWe(coreWe), .coreIdx(coreIdx), .coreWdata(coreWdata),
    .coreRdata(coreRdata), .ctxValid(ctxValid), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memRdata(memRdata), .memGnt(memGnt)
  );

  assign memRdata = dutMem[memAddr];
  assign memGnt   = lfsr[0] | lfsr[2];

  task automatic chk(string tag, int act, int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  function automatic int expAddr();
    if (refMode == 1) return (refPcbOut + 1 + refCnt) & 255;
    if (refMode == 3) return (refCand + 1 + refCnt) & 255;
    return refPcbAct;
  endfunction

  // reference step, memory and grant pattern
  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      foreach (refBank[b, i]) refBank[b][i] = 0;
      refAct = 0; refPcbAct = 0; refPcbIdle = 0; refPcbOut = 0;
      refCand = 0; refMode = 4; refCnt = 0; refPend = 1;
    end else begin
      automatic bit take = swReq && (swCause < 2) && (refPend == 0);
      automatic bit xfer = (refMode >= 1 && refMode <= 3) && memGnt;
      if (coreWe && refPend == 0) refBank[refAct][coreIdx] = coreWdata;
      if (refMode != 0 && take) refPend = 1;
      case (refMode)
        0: if (refPend == 1 || take) begin
             refPend = 0; refPcbOut = refPcbAct; refPcbAct = refPcbIdle;
             refAct = 1 - refAct; refCnt = 0;
             refMode = (refPcbOut == 0) ? 2 : 1;
           end
        1: if (xfer) begin
             refMem[(refPcbOut + 1 + refCnt) & 255] = refBank[1-refAct][refCnt];
             if (refCnt == 3) begin refCnt = 0; refMode = 2; end else refCnt++;
           end
        2: if (xfer) begin
             automatic int nxt = refMem[refPcbAct] & 255;
             refCnt = 0;
             if (nxt == 0) refMode = 4; else begin refCand = nxt; refMode = 3; end
           end
        3: if (xfer) begin
             refBank[1-refAct][refCnt] = refMem[(refCand + 1 + refCnt) & 255];
             if (refCnt == 3) begin refCnt = 0; refPcbIdle = refCand; refMode = 0; end
             else refCnt++;
           end
        default: if (resched && headPtr != 0) begin
             refCand = headPtr; refCnt = 0; refMode = 3;
           end
      endcase
    end
    if (memReq && memWe && memGnt) dutMem[memAddr] <= memWdata;
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (cyc > 20000) begin
      nChk++; nBad++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", cyc, 20000);
      summary();
    end
  end

  // per-cycle comparison against the reference
  always @(negedge clk) begin
    if (rstN) begin
      chk("R4 ctxValid", int'(ctxValid), (refPend == 0) ? 1 : 0);
      chk("R1 coreRdata", int'(coreRdata), refBank[refAct][coreIdx]);
      chk("R8 memReq", int'(memReq), (refMode >= 1 && refMode <= 3) ? 1 : 0);
      if (memReq) begin
        chk("R6 memAddr", int'(memAddr), expAddr());
        chk("R5 memWe", int'(memWe), (refMode == 1) ? 1 : 0);
        if (memWe) chk("R5 memWdata", int'(memWdata), refBank[1-refAct][refCnt]);
      end
    end
  end

  task automatic tick(); @(posedge clk); #2; endtask
  task automatic ticks(int n); repeat (n) tick(); endtask

  task automatic pulseSw(logic [1:0] cause);
    swCause = cause; swReq = 1'b1; tick(); swReq = 1'b0;
  endtask

  task automatic pulseRes(logic [AW-1:0] h);
    headPtr = h; resched = 1'b1; tick(); resched = 1'b0;
  endtask

  task automatic waitValid();
    for (int i = 0; i < 400; i++) begin
      if (ctxValid) break;
      tick();
    end
  endtask

  task automatic readIdx(int i, string tag, int exp);
    coreIdx = 2'(i); #1; chk(tag, int'(coreRdata), exp);
  endtask

  initial begin
    for (int a = 0; a < 256; a++) begin dutMem[a] = '0; refMem[a] = 0; end
    for (int p = 1; p <= 4; p++) begin
      automatic int base = p * 16;
      automatic int nx = (p == 4) ? 0 : base + 16;
      dutMem[base] = DW'(nx); refMem[base] = nx;
      for (int k = 0; k < 4; k++) begin
        dutMem[base+1+k] = DW'(p * 256 + k); refMem[base+1+k] = p * 256 + k;
      end
    end
    ticks(3);
    #1;
    chk("R9 reset ctxValid", int'(ctxValid), 0);
    chk("R9 reset memReq", int'(memReq), 0);
    chk("R9 reset bank", int'(coreRdata), 0);
    rstN = 1'b1;
    tick();
    // boot: first loaded task becomes active
    pulseRes(8'h10);
    waitValid();
    readIdx(0, "R9 boot status word", 16'h0100);
    ticks(60);
    // core write then readback
    coreIdx = 2'd1; coreWdata = 16'hABCD; coreWe = 1'b1; tick(); coreWe = 1'b0;
    readIdx(1, "R1 write readback", 16'hABCD);
    // trap: no swap
    pulseSw(2'd2);
    #3;
    readIdx(1, "R3 trap keeps context", 16'hABCD);
    chk("R3 trap keeps valid", int'(ctxValid), 1);
    // terminate with ready shadow: immediate swap
    pulseSw(2'd0);
    readIdx(0, "R2 R6 swapped to prefetched task", 16'h0200);
    chk("R2 valid after swap", int'(ctxValid), 1);
    // request during save: held
    pulseSw(2'd1);
    #3;
    chk("R4 stall while busy", int'(ctxValid), 0);
    waitValid();
    readIdx(0, "R4 held request served", 16'h0300);
    ticks(60);
    pulseSw(2'd0);
    readIdx(0, "R2 swap to last task", 16'h0400);
    ticks(60);
    // list exhausted: request stalls until reschedule
    pulseSw(2'd0);
    coreIdx = 2'd2; coreWdata = 16'h5555; coreWe = 1'b1; tick(); coreWe = 1'b0;
    ticks(30);
    chk("R7 empty list stalls", int'(ctxValid), 0);
    pulseRes(8'h00);
    ticks(30);
    chk("R7 null head keeps waiting", int'(ctxValid), 0);
    pulseRes(8'h20);
    waitValid();
    readIdx(0, "R7 reload from head", 16'h0200);
    ticks(60);
    chk("R1 write while invalid ignored", int'(dutMem[8'h43]), 16'h0402);
    chk("R5 saved register", int'(dutMem[8'h12]), 16'hABCD);
    chk("R5 saved status word", int'(dutMem[8'h11]), 16'h0100);
    // reschedule while halted has no effect
    pulseRes(8'h10);
    ticks(5);
    pulseSw(2'd1);
    readIdx(0, "R7 resched ignored when halted", 16'h0300);
    ticks(60);
    begin
      automatic int diff = 0;
      for (int a = 0; a < 256; a++) if (int'(dutMem[a]) != refMem[a]) diff++;
      chk("R5 R6 memory image", diff, 0);
    end
    summary();
  end

endmodule